// File: doc/BRIEF.md
# Event Address Mapper

This block turns a stream of incoming address-events into a stream of outgoing address-events. Arriving events are queued in a small input FIFO, so arrival is decoupled from output generation. A single mapping engine takes them out one at a time and handles each one according to the selected mode. In copy mode the address is forwarded as it is. In single-target mode the address selects one word of an internal mapping table, and the target in that word is emitted. In fan-out mode the address marks where a list of targets begins in the table, and one output event is emitted for each entry until the list ends.

The table is loaded through a configuration write port while the mapper is disabled. Once it is filled and the mapper is enabled, mapping runs without any outside involvement. The output side uses a valid/ready handshake. The engine does not take the next input event until every output produced by the current one has been accepted.

Top module: `event_mapper`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and every table entry is invalid, so a single-target lookup made before any configuration write produces no output.
- R2: The input FIFO holds FIFO_DEPTH events. `in_ready` is 0 while it is full, and an event offered while `in_ready` is 0 is dropped.
- R3: Events are served in arrival order and only while `enable` is 1. While `enable` is 0 no event leaves the FIFO and no output is produced.
- R4: `mode` selects the mapping: 0 is copy, 1 is single-target, 2 is fan-out, and 3 behaves as copy. In copy mode `out_addr` equals the input address, and `out_valid` rises two clock edges after the edge that accepted the event into an empty, idle mapper.
- R5: In single-target mode the entry at index `in_addr` is read, and its target is presented three edges after the accepting edge.
- R6: A table entry has three fields: a valid flag, a last flag and a target address. An invalid entry emits nothing. In single-target mode the input then produces no output at all. In fan-out mode the list ends at that entry and the entry emits nothing.
- R7: In fan-out mode the entries are visited at consecutive indices starting at `in_addr`, and the index wraps from the top of the table to 0. Each valid entry emits its target, and the entry whose last flag is set ends the list. Each following target is presented two edges after the previous one was accepted.
- R8: A fan-out traversal visits at most as many entries as the table holds, even if no last flag is set.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_addr` stays stable. A transfer happens on an edge where both are 1.
- R10: The next input event is not taken from the FIFO until every output of the current event has been transferred.
- R11: A configuration write changes the table only while `enable` is 0. A write made while `enable` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | 1 lets the engine map events; 0 holds the engine and opens table writes |
| mode | input | 2 | Mapping mode: 0 copy, 1 single-target, 2 fan-out, 3 copy |
| in_valid | input | 1 | An input event is offered |
| in_addr | input | ADDR_W | Address of the input event |
| in_ready | output | 1 | The input FIFO has room |
| out_valid | output | 1 | An output event is presented |
| out_addr | output | ADDR_W | Address of the output event |
| out_ready | input | 1 | Downstream accepts the output event |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | ADDR_W | Table index to write |
| cfg_valid | input | 1 | Valid flag of the written entry |
| cfg_last | input | 1 | Last-of-list flag of the written entry |
| cfg_target | input | ADDR_W | Target address of the written entry |

## Verification
All latencies are counted from the edge that accepts an event into an empty FIFO while the engine is idle and `out_ready` is 1. A copied address is due at the second edge after that one. A single-target result is due at the third, and fan-out targets follow at the third, fifth, seventh edge and so on. Directed probes sample on the falling edge after each of these rising edges and record the index of every cycle that shows `out_valid`, so an output that arrives early or late changes the recorded index. A behavioural queue model, filled when events are accepted, checks the address on every falling edge that shows `out_valid`, including stretches where `out_ready` is throttled.

// File: rtl/evmap_pkg.sv
package evmap_pkg;

    typedef enum logic [1:0] {
        MODE_COPY   = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_FANOUT = 2'd2,
        MODE_ALT    = 2'd3
    } map_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_EMIT = 2'd2
    } eng_state_e;

endpackage

// File: rtl/evmap_fifo.sv
module evmap_fifo #(
    parameter int W     = 6,
    parameter int DEPTH = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic         full_o,
    output logic         empty_o,
    output logic [W-1:0] head_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t     s_d, s_q;
    logic [W-1:0] mem_q [DEPTH];
    logic         do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (s_q.cnt == CW'(DEPTH));
    assign empty_o = (s_q.cnt == '0);
    assign head_o  = mem_q[s_q.rd];
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;

    always_comb begin
        s_d = s_q;
        if (do_push) s_d.wr = bump(s_q.wr);
        if (do_pop)  s_d.rd = bump(s_q.rd);
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    always_ff @(posedge clk_i) begin
        if (do_push) mem_q[s_q.wr] <= data_i;
    end

    // R2: an offer made while full, with no pop, leaves the occupancy unchanged
    a_r2_drop_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && full_o && !pop_i) |=> (s_q.cnt == $past(s_q.cnt)));

    // R2: a full queue keeps in_ready low until something leaves
    a_r2_full_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && !pop_i) |=> full_o);

endmodule

// File: rtl/evmap_table.sv
module evmap_table #(
    parameter int AW = 6,
    parameter int EW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          lock_i,
    input  logic          wr_req_i,
    input  logic [AW-1:0] wr_idx_i,
    input  logic [EW-1:0] wr_data_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] rd_idx_i,
    output logic [EW-1:0] rd_data_o
);
    localparam int DEPTH = 1 << AW;

    logic [EW-1:0] mem_q [DEPTH];
    logic [EW-1:0] rd_q;
    logic          wr_en;

    assign wr_en     = wr_req_i && !lock_i;
    assign rd_data_o = rd_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            rd_q <= '0;
        end else begin
            if (wr_en)   mem_q[wr_idx_i] <= wr_data_i;
            if (rd_en_i) rd_q <= mem_q[rd_idx_i];
        end
    end

    // R11: a write strobe while the mapper runs leaves the addressed word untouched
    a_r11_locked_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_req_i && lock_i) |=> (mem_q[$past(wr_idx_i)] == $past(mem_q[wr_idx_i])));

endmodule

// File: rtl/evmap_engine.sv
module evmap_engine import evmap_pkg::*; #(
    parameter int AW = 6
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          enable_i,
    input  map_mode_e     mode_i,
    input  logic          fifo_empty_i,
    input  logic [AW-1:0] fifo_head_i,
    output logic          pop_o,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_idx_o,
    input  logic          ent_valid_i,
    input  logic          ent_last_i,
    input  logic [AW-1:0] ent_target_i,
    output logic          out_valid_o,
    output logic [AW-1:0] out_addr_o,
    input  logic          out_ready_i
);
    localparam int DEPTH = 1 << AW;
    localparam int VW    = AW + 1;

    typedef struct packed {
        eng_state_e    st;
        logic          fan;
        logic          last;
        logic [AW-1:0] idx;
        logic [VW-1:0] visits;
        logic [AW-1:0] addr;
    } eng_st_t;

    eng_st_t s_d, s_q;
    logic    uses_table;

    assign uses_table  = (mode_i == MODE_SINGLE) || (mode_i == MODE_FANOUT);
    assign out_valid_o = (s_q.st == ST_EMIT);
    assign out_addr_o  = s_q.addr;

    always_comb begin
        s_d      = s_q;
        pop_o    = 1'b0;
        rd_en_o  = 1'b0;
        rd_idx_o = s_q.idx;
        case (s_q.st)
            ST_IDLE: begin
                if (enable_i && !fifo_empty_i) begin
                    pop_o      = 1'b1;
                    s_d.idx    = fifo_head_i;
                    s_d.visits = '0;
                    s_d.fan    = (mode_i == MODE_FANOUT);
                    if (uses_table) begin
                        rd_en_o  = 1'b1;
                        rd_idx_o = fifo_head_i;
                        s_d.st   = ST_LOOK;
                    end else begin
                        s_d.addr = fifo_head_i;
                        s_d.last = 1'b1;
                        s_d.st   = ST_EMIT;
                    end
                end
            end
            ST_LOOK: begin
                s_d.visits = s_q.visits + 1'b1;
                if (!ent_valid_i) begin
                    s_d.st = ST_IDLE;
                end else begin
                    s_d.addr = ent_target_i;
                    s_d.last = !s_q.fan || ent_last_i ||
                               ((s_q.visits + 1'b1) == VW'(DEPTH));
                    s_d.st   = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (out_ready_i) begin
                    if (s_q.last) begin
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.idx  = s_q.idx + 1'b1;
                        rd_en_o  = 1'b1;
                        rd_idx_o = s_q.idx + 1'b1;
                        s_d.st   = ST_LOOK;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // R9: a stalled output keeps its address until accepted
    a_r9_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_addr_o)));

    // R3: no event leaves the queue while the mapper is disabled
    a_r3_no_pop_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |-> !pop_o);

    // R4: a copied event appears on the next cycle with the queue head address
    a_r4_copy_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_o && !uses_table) |=> (out_valid_o && out_addr_o == $past(fifo_head_i)));

    // R10: a presented output blocks any further pop
    a_r10_no_pop_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_ready_i) |=> !pop_o);

    // R8: the traversal never visits more entries than the table holds
    a_r8_visit_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.visits <= VW'(DEPTH));

endmodule

// File: rtl/event_mapper.sv
module event_mapper import evmap_pkg::*; #(
    parameter int ADDR_W     = 6,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        mode,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              in_ready,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    input  logic              out_ready,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_idx,
    input  logic              cfg_valid,
    input  logic              cfg_last,
    input  logic [ADDR_W-1:0] cfg_target
);
    localparam int EW = ADDR_W + 2;

    map_mode_e         mode_e;
    logic              fifo_full, fifo_empty, fifo_pop;
    logic [ADDR_W-1:0] fifo_head;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_idx;
    logic [EW-1:0]     rd_word;
    logic [EW-1:0]     wr_word;

    assign mode_e   = map_mode_e'(mode);
    assign in_ready = !fifo_full;
    assign wr_word  = {cfg_valid, cfg_last, cfg_target};

    evmap_fifo #(.W(ADDR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .push_i  (in_valid),
        .data_i  (in_addr),
        .pop_i   (fifo_pop),
        .full_o  (fifo_full),
        .empty_o (fifo_empty),
        .head_o  (fifo_head)
    );

    evmap_table #(.AW(ADDR_W), .EW(EW)) u_table (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .lock_i    (enable),
        .wr_req_i  (cfg_we),
        .wr_idx_i  (cfg_idx),
        .wr_data_i (wr_word),
        .rd_en_i   (rd_en),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_word)
    );

    evmap_engine #(.AW(ADDR_W)) u_engine (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .enable_i     (enable),
        .mode_i       (mode_e),
        .fifo_empty_i (fifo_empty),
        .fifo_head_i  (fifo_head),
        .pop_o        (fifo_pop),
        .rd_en_o      (rd_en),
        .rd_idx_o     (rd_idx),
        .ent_valid_i  (rd_word[EW-1]),
        .ent_last_i   (rd_word[EW-2]),
        .ent_target_i (rd_word[ADDR_W-1:0]),
        .out_valid_o  (out_valid),
        .out_addr_o   (out_addr),
        .out_ready_i  (out_ready)
    );

    // R2: a full queue shows in_ready low on the port
    a_r2_ready_when_room: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !fifo_pop) |=> !in_ready);

endmodule

// File: tb/event_mapper_tb.sv
module event_mapper_tb;
    localparam int AW    = 6;
    localparam int FD    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic          in_ready;
    logic          out_valid;
    logic [AW-1:0] out_addr;
    logic          out_ready = 1'b1;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_idx = '0;
    logic          cfg_valid = 1'b0;
    logic          cfg_last = 1'b0;
    logic [AW-1:0] cfg_target = '0;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    int lat_n[$];
    int lat_a[$];
    bit tv[DEPTH];
    bit tl[DEPTH];
    int tt[DEPTH];
    int vcount = 0;
    int hs_cnt = 0;
    int acc_cnt = 0;
    bit bp_on = 1'b0;
    int bp_cnt = 0;

    always #2 clk = ~clk;

    event_mapper #(.ADDR_W(AW), .FIFO_DEPTH(FD)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
        .in_valid(in_valid), .in_addr(in_addr), .in_ready(in_ready),
        .out_valid(out_valid), .out_addr(out_addr), .out_ready(out_ready),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
        .cfg_last(cfg_last), .cfg_target(cfg_target)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // behavioural reference: expected outputs of one accepted event
    function automatic void model_event(input int a);
        int idx;
        case (int'(mode))
            1: if (tv[a]) exp_q.push_back(tt[a]);
            2: begin
                idx = a;
                for (int n = 0; n < DEPTH; n++) begin
                    if (!tv[idx]) break;
                    exp_q.push_back(tt[idx]);
                    if (tl[idx]) break;
                    idx = (idx + 1) % DEPTH;
                end
            end
            default: exp_q.push_back(a);
        endcase
    endfunction

    // per-cycle comparison against the model, sampled mid-cycle
    always @(negedge clk) begin
        int e;
        if (rst_n) begin
            if (out_valid) begin
                vcount++;
                e = (exp_q.size() > 0) ? exp_q[0] : -1;
                chk(out_addr == AW'(e) && e >= 0, "R7 output stream", int'(out_addr), e);
                if (out_ready) begin
                    hs_cnt++;
                    if (exp_q.size() > 0) void'(exp_q.pop_front());
                end
            end
            if (cfg_we && !enable) begin
                tv[cfg_idx] = cfg_valid;
                tl[cfg_idx] = cfg_last;
                tt[cfg_idx] = int'(cfg_target);
            end
            if (in_valid && in_ready) begin
                acc_cnt++;
                model_event(int'(in_addr));
            end
        end
    end

    // throttled downstream acceptance
    always @(posedge clk) begin
        #1;
        if (bp_on) begin
            bp_cnt++;
            out_ready = (bp_cnt % 3) != 0;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input int a);
        in_valid = 1'b1;
        in_addr  = AW'(a);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic cfg_write(input int idx, input bit v, input bit l, input int t);
        cfg_we     = 1'b1;
        cfg_idx    = AW'(idx);
        cfg_valid  = v;
        cfg_last   = l;
        cfg_target = AW'(t);
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic drain(input string req);
        int guard;
        guard = 0;
        while ((exp_q.size() > 0 || out_valid) && guard < 3000) begin
            @(posedge clk);
            #1;
            guard++;
        end
        tick(4);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    // push one event and record at which falling edge each output shows
    task automatic probe(input int a, input int n_max);
        lat_n.delete();
        lat_a.delete();
        push(a);
        for (int n = 1; n <= n_max; n++) begin
            @(negedge clk);
            if (out_valid) begin
                lat_n.push_back(n);
                lat_a.push_back(int'(out_addr));
            end
        end
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL R3 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int v0, a0, h0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        @(posedge clk);
        #1;

        // R1: table empty after reset
        v0 = vcount;
        enable = 1'b1;
        mode = 2'd1;
        push(9);
        tick(8);
        chk(vcount == v0, "R1 lookup on empty table", vcount - v0, 0);

        // R4: copy mode latency and value
        mode = 2'd0;
        probe(21, 6);
        chk(lat_n.size() == 1 && lat_n[0] == 2, "R4 copy latency",
            (lat_n.size() > 0) ? lat_n[0] : -1, 2);
        chk(lat_a.size() == 1 && lat_a[0] == 21, "R4 copy address",
            (lat_a.size() > 0) ? lat_a[0] : -1, 21);

        // R4: burst under throttled acceptance
        bp_on = 1'b1;
        for (int i = 0; i < 6; i++) push(i * 7 + 3);
        drain("R4 copy burst served");
        bp_on = 1'b0;
        out_ready = 1'b1;

        // R4: mode 3 behaves as copy
        mode = 2'd3;
        push(50);
        push(51);
        drain("R4 mode 3 copies");

        // table load while disabled
        enable = 1'b0;
        cfg_write(5, 1, 0, 40);
        cfg_write(6, 0, 0, 7);
        cfg_write(10, 1, 0, 1);
        cfg_write(11, 1, 0, 2);
        cfg_write(12, 1, 1, 3);
        cfg_write(62, 1, 0, 4);
        cfg_write(63, 1, 0, 5);
        cfg_write(0, 1, 1, 6);
        cfg_write(20, 1, 0, 9);
        cfg_write(21, 0, 1, 8);

        // R11: write while enabled is ignored; R5 latency
        enable = 1'b1;
        cfg_write(5, 1, 1, 33);
        mode = 2'd1;
        probe(5, 8);
        chk(lat_n.size() == 1 && lat_n[0] == 3, "R5 single-target latency",
            (lat_n.size() > 0) ? lat_n[0] : -1, 3);
        chk(lat_a.size() == 1 && lat_a[0] == 40, "R11 enabled write ignored",
            (lat_a.size() > 0) ? lat_a[0] : -1, 40);

        // R6: invalid entry in single-target mode
        v0 = vcount;
        push(6);
        tick(10);
        chk(vcount == v0, "R6 invalid entry silent", vcount - v0, 0);

        // R6: invalid entry ends a fan-out list
        mode = 2'd2;
        probe(20, 10);
        chk(lat_a.size() == 1, "R6 list stops at invalid entry", lat_a.size(), 1);
        chk(lat_a.size() > 0 && lat_a[0] == 9, "R6 list first target",
            (lat_a.size() > 0) ? lat_a[0] : -1, 9);

        // R7: fan-out timing and order
        probe(10, 10);
        chk(lat_n.size() == 3, "R7 fan-out count", lat_n.size(), 3);
        for (int k = 0; k < 3; k++) begin
            chk(lat_n.size() == 3 && lat_n[k] == 3 + 2 * k, "R7 fan-out timing",
                (lat_n.size() == 3) ? lat_n[k] : -1, 3 + 2 * k);
            chk(lat_a.size() == 3 && lat_a[k] == k + 1, "R7 fan-out target",
                (lat_a.size() == 3) ? lat_a[k] : -1, k + 1);
        end

        // R7: wrap across the top of the table
        probe(62, 10);
        chk(lat_a.size() == 3 && lat_a[2] == 6, "R7 wrap to index 0",
            (lat_a.size() == 3) ? lat_a[2] : -1, 6);

        // R7 and R10: queued lists under throttling keep order
        bp_on = 1'b1;
        push(10);
        push(62);
        push(20);
        drain("R10 queued lists served in order");
        bp_on = 1'b0;
        out_ready = 1'b1;

        // R10 and R9: stalled output blocks the queue
        out_ready = 1'b0;
        push(10);
        for (int i = 0; i < FD; i++) push(20);
        chk(in_ready == 1'b0, "R10 queue held while output pending", int'(in_ready), 0);
        chk(out_valid == 1'b1 && out_addr == AW'(1), "R9 stalled output held",
            int'(out_addr), 1);
        out_ready = 1'b1;
        drain("R10 backlog served");

        // R3: disabled mapper holds events
        enable = 1'b0;
        mode = 2'd0;
        v0 = vcount;
        push(30);
        push(31);
        push(32);
        tick(10);
        chk(vcount == v0, "R3 no output while disabled", vcount - v0, 0);
        enable = 1'b1;
        drain("R3 held events served after enable");

        // R2: capacity and drop on full
        enable = 1'b0;
        a0 = acc_cnt;
        for (int i = 0; i < FD + 2; i++) push(40 + i);
        chk(acc_cnt - a0 == FD, "R2 accepted up to capacity", acc_cnt - a0, FD);
        chk(in_ready == 1'b0, "R2 in_ready low when full", int'(in_ready), 0);
        enable = 1'b1;
        drain("R2 only accepted events emitted");

        // R8: list without a last flag is capped at the table size
        enable = 1'b0;
        for (int i = 0; i < DEPTH; i++) cfg_write(i, 1, 0, i);
        enable = 1'b1;
        mode = 2'd2;
        h0 = hs_cnt;
        push(7);
        drain("R8 capped traversal served");
        chk(hs_cnt - h0 == DEPTH, "R8 traversal cap", hs_cnt - h0, DEPTH);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule